// File: doc/BRIEF.md
# Selectable-Polynomial Byte CRC Engine

This block accumulates a cyclic redundancy check over a byte stream of any length. Each byte offered on a valid/ready input is folded into a 16-bit accumulator in one clock cycle by an unrolled eight-step network. Two configuration pins select one of three generators and the bit order of the serial link the code is meant for. Software clears the accumulator before a message, writes the bytes, and reads the result from `crc_out`.

The byte input follows valid/ready rules. A byte is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` drops only in a cycle where the accumulator is being cleared: while `clear` is high, or in the cycle where the configuration differs from its value in the previous cycle. A byte offered in such a cycle is not taken, and the source must hold it until `in_ready` returns. Because the accumulator starts from zero and has no output inversion, its value after a message is the plain CRC of that message.

Top module: `crc_calc`

## Requirements
- R1: After reset `crc_out` is 0, and `in_ready` is high when `clear` is low and the configuration is steady.
- R2: `cfg_poly` = 0 selects the 8-bit generator x^8+x^2+x+1 (0x07). The result is in `crc_out[7:0]` and `crc_out[15:8]` reads 0. MSB-first over ASCII "123456789" gives 0xF4.
- R3: `cfg_poly` = 1 selects x^16+x^15+x^2+1 (0x8005). Over "123456789", MSB-first gives 0xFEE8 and LSB-first gives 0xBB3D.
- R4: `cfg_poly` = 2 selects x^16+x^12+x^5+1 (0x1021). Over "123456789", MSB-first gives 0x31C3 and LSB-first gives 0x2189. The reserved code 3 behaves exactly like code 2.
- R5: With `cfg_lsb_first` = 0, bit 7 of each byte is processed first in a left-shifting register. With `cfg_lsb_first` = 1, bit 0 is processed first in a right-shifting register that uses the bit-reversed generator, so the result is bit-reversed.
- R6: Each accepted byte updates `crc_out` at the rising edge that accepts it. In cycles where no byte is accepted and no clear takes place, `crc_out` holds its value.
- R7: When `clear` is high, `in_ready` is low and `crc_out` is 0 after the next edge. A byte offered in that cycle is not taken.
- R8: In a cycle where {`cfg_poly`, `cfg_lsb_first`} differs from its value in the previous cycle, `in_ready` is low and `crc_out` is 0 after the next edge.
- R9: A message of any length, including a few hundred bytes, produces the same result as the byte-at-a-time definition of the selected CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_poly | input | 2 | Generator select: 0 = 8-bit 0x07, 1 = 0x8005, 2 and 3 = 0x1021 |
| cfg_lsb_first | input | 1 | 1 = bit 0 of each byte first (reflected), 0 = bit 7 first |
| clear | input | 1 | Zero the accumulator at the next edge |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_ready | output | 1 | The offered byte will be taken at this edge |
| in_data | input | 8 | Byte to fold into the CRC |
| crc_out | output | 16 | Accumulated CRC; upper byte is 0 in 8-bit mode |

## Verification
The assertions check the control rules on every cycle: a clear or a configuration change drops `in_ready` and zeroes the accumulator on the next edge, the result holds when no byte is offered, and the upper byte stays at zero in 8-bit mode. Only the bench's scenarios can show that the arithmetic is correct. It does this with known check values for each generator and bit order, a reference model run over a long stream, the behaviour of the reserved generator code, and a byte offered in the same cycle as a clear being refused.

// File: rtl/crc_calc_pkg.sv
package crc_calc_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam int NARROW_W = 8;

  typedef struct packed {
    logic [1:0] poly;
    logic       lsb_first;
  } crc_cfg_t;

  localparam logic [CRC_W-1:0] GEN_NARROW = 16'h0007;
  localparam logic [CRC_W-1:0] GEN_WIDE_A = 16'h8005;
  localparam logic [CRC_W-1:0] GEN_WIDE_B = 16'h1021;

  // Bit-reverse the low w bits of v; bits at w and above read as zero.
  function automatic logic [CRC_W-1:0] reflect_low(input logic [CRC_W-1:0] v, input int w);
    logic [CRC_W-1:0] r;
    r = '0;
    for (int i = 0; i < CRC_W; i++) begin
      if (i < w) r[w-1-i] = v[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/crc_poly_sel.sv
module crc_poly_sel
  import crc_calc_pkg::*;
(
  input  crc_cfg_t          cfg,
  output logic [CRC_W-1:0]  taps,
  output logic              wide
);
  logic [CRC_W-1:0] gen;

  always_comb begin
    unique case (cfg.poly)
      2'd0:    begin gen = GEN_NARROW; wide = 1'b0; end
      2'd1:    begin gen = GEN_WIDE_A; wide = 1'b1; end
      default: begin gen = GEN_WIDE_B; wide = 1'b1; end
    endcase
    taps = cfg.lsb_first ? reflect_low(gen, wide ? CRC_W : NARROW_W) : gen;
  end
endmodule

// File: rtl/crc_bit_step.sv
module crc_bit_step
  import crc_calc_pkg::*;
(
  input  logic [CRC_W-1:0] c_in,
  input  logic             din,
  input  logic [CRC_W-1:0] taps,
  input  logic             wide,
  input  logic             lsb_first,
  output logic [CRC_W-1:0] c_out
);
  logic             fb;
  logic [CRC_W-1:0] sh;

  always_comb begin
    if (lsb_first) begin
      fb = c_in[0] ^ din;
      sh = c_in >> 1;
    end else begin
      fb = (wide ? c_in[CRC_W-1] : c_in[NARROW_W-1]) ^ din;
      sh = c_in << 1;
      if (!wide) sh[CRC_W-1:NARROW_W] = '0;
    end
    c_out = fb ? (sh ^ taps) : sh;
  end
endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step
  import crc_calc_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic [CRC_W-1:0]  c_in,
  input  logic [DATA_W-1:0] data,
  input  logic [CRC_W-1:0]  taps,
  input  logic              wide,
  input  logic              lsb_first,
  output logic [CRC_W-1:0]  c_out
);
  logic [CRC_W-1:0] chain [DATA_W+1];

  assign chain[0] = c_in;

  for (genvar k = 0; k < DATA_W; k++) begin : g_stage
    logic bit_k;
    assign bit_k = lsb_first ? data[k] : data[DATA_W-1-k];
    crc_bit_step u_step (
      .c_in      (chain[k]),
      .din       (bit_k),
      .taps      (taps),
      .wide      (wide),
      .lsb_first (lsb_first),
      .c_out     (chain[k+1])
    );
  end

  assign c_out = chain[DATA_W];
endmodule

// File: rtl/crc_cfg_track.sv
module crc_cfg_track
  import crc_calc_pkg::*;
(
  input  logic     clk,
  input  crc_cfg_t cfg,
  output logic     changed
);
  crc_cfg_t cfg_q;

  always_ff @(posedge clk) cfg_q <= cfg;

  assign changed = (cfg_q != cfg);
endmodule

// File: rtl/crc_calc.sv
module crc_calc
  import crc_calc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_poly,
  input  logic              cfg_lsb_first,
  input  logic              clear,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic [CRC_W-1:0]  crc_out
);
  crc_cfg_t         cfg;
  logic             cfg_changed;
  logic [CRC_W-1:0] taps;
  logic             wide;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_next;

  assign cfg = '{poly: cfg_poly, lsb_first: cfg_lsb_first};

  crc_cfg_track u_track (
    .clk     (clk),
    .cfg     (cfg),
    .changed (cfg_changed)
  );

  crc_poly_sel u_sel (
    .cfg  (cfg),
    .taps (taps),
    .wide (wide)
  );

  crc_byte_step #(.DATA_W(BYTE_W)) u_net (
    .c_in      (crc_q),
    .data      (in_data),
    .taps      (taps),
    .wide      (wide),
    .lsb_first (cfg_lsb_first),
    .c_out     (crc_next)
  );

  assign in_ready = !(clear || cfg_changed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  crc_q <= '0;
    else if (!in_ready)          crc_q <= '0;
    else if (in_valid)           crc_q <= crc_next;
  end

  assign crc_out = crc_q;
endmodule

// File: rtl/crc_calc_chk.sv
module crc_calc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cfg_poly,
  input logic        cfg_lsb_first,
  input logic        clear,
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] crc_out
);
  a_r7_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !in_ready);

  a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_out == 16'h0));

  a_r8_cfg_change_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cfg_poly, cfg_lsb_first}) |-> !in_ready);

  a_r8_cfg_change_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cfg_poly, cfg_lsb_first}) |=> (crc_out == 16'h0));

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(crc_out));

  a_r2_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_poly == 2'd0 && in_ready) |=> (crc_out[15:8] == 8'h0));
endmodule

bind crc_calc crc_calc_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_poly      (cfg_poly),
  .cfg_lsb_first (cfg_lsb_first),
  .clear         (clear),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .crc_out       (crc_out)
);

// File: tb/tb_crc_calc.sv
module tb_crc_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_poly = 2'd0;
  logic        cfg_lsb_first = 1'b0;
  logic        clear = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic [15:0] crc_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  crc_calc dut (
    .clk(clk), .rst_n(rst_n), .cfg_poly(cfg_poly), .cfg_lsb_first(cfg_lsb_first),
    .clear(clear), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .crc_out(crc_out)
  );

  // {poly, lsb_first, check value over "123456789"}
  localparam logic [18:0] VEC [5] = '{
    {2'd0, 1'b0, 16'h00F4},   // R2
    {2'd1, 1'b0, 16'hFEE8},   // R3
    {2'd1, 1'b1, 16'hBB3D},   // R3 R5
    {2'd2, 1'b0, 16'h31C3},   // R4
    {2'd2, 1'b1, 16'h2189}    // R4 R5
  };

  // Byte-wise reference: xor the byte in, then eight shift/reduce steps.
  function automatic logic [15:0] model(input logic [15:0] c, input logic [7:0] b,
                                        input logic [1:0] p, input logic lsb);
    logic [15:0] g;
    logic [15:0] rg;
    int w;
    logic [15:0] m;
    if (p == 2'd0) begin g = 16'h0007; w = 8; end
    else if (p == 2'd1) begin g = 16'h8005; w = 16; end
    else begin g = 16'h1021; w = 16; end
    m = (w == 16) ? 16'hFFFF : 16'h00FF;
    rg = '0;
    for (int i = 0; i < w; i++) rg[w-1-i] = g[i];
    if (lsb) begin
      c = c ^ {8'h00, b};
      for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ rg) : (c >> 1);
    end else begin
      c = c ^ (16'(b) << (w - 8));
      for (int i = 0; i < 8; i++) c = c[w-1] ? (((c << 1) ^ g) & m) : ((c << 1) & m);
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] p, input logic l);
    cfg_poly = p;
    cfg_lsb_first = l;
    @(negedge clk);
  endtask

  task automatic do_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic send_check_msg();
    for (int i = 1; i <= 9; i++) send(8'h30 + 8'(i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] ref_c;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset value", crc_out, 16'h0000);
    chk("R1 ready after reset", {15'h0, in_ready}, 16'h0001);

    // Vector table walk: known check values.
    for (int v = 0; v < 5; v++) begin
      set_cfg(VEC[v][18:17], VEC[v][16]);
      do_clear();
      send_check_msg();
      chk("R2 R3 R4 R5 check value", crc_out, VEC[v][15:0]);
    end

    // 8-bit reflected mode against the model; upper byte stays zero (R2 R5).
    set_cfg(2'd0, 1'b1);
    do_clear();
    ref_c = '0;
    for (int i = 1; i <= 9; i++) ref_c = model(ref_c, 8'h30 + 8'(i), 2'd0, 1'b1);
    send_check_msg();
    chk("R5 narrow reflected", crc_out, ref_c);
    chk("R2 upper byte zero", {8'h00, crc_out[15:8]}, 16'h0000);

    // Reserved code 3 behaves as code 2 (R4).
    set_cfg(2'd3, 1'b0);
    do_clear();
    send_check_msg();
    chk("R4 reserved code", crc_out, 16'h31C3);

    // Idle cycles hold the value (R6).
    held = crc_out;
    repeat (4) @(negedge clk);
    chk("R6 hold when idle", crc_out, held);

    // Single byte updates at the accepting edge (R6).
    set_cfg(2'd2, 1'b0);
    send(8'hA5);
    chk("R6 single byte", crc_out, model(16'h0, 8'hA5, 2'd2, 1'b0));

    // Clear with a byte offered: byte refused, value zero (R7).
    clear = 1'b1;
    in_valid = 1'b1;
    in_data = 8'h5A;
    #1;
    chk("R7 ready low during clear", {15'h0, in_ready}, 16'h0000);
    @(negedge clk);
    clear = 1'b0;
    in_valid = 1'b0;
    chk("R7 cleared, byte ignored", crc_out, 16'h0000);

    // Configuration change clears (R8).
    send(8'h11);
    send(8'h22);
    cfg_lsb_first = 1'b1;
    #1;
    chk("R8 ready low on cfg change", {15'h0, in_ready}, 16'h0000);
    @(negedge clk);
    chk("R8 cleared by cfg change", crc_out, 16'h0000);
    chk("R8 ready back", {15'h0, in_ready}, 16'h0001);

    // Long stream against the model (R9).
    set_cfg(2'd1, 1'b0);
    do_clear();
    ref_c = '0;
    for (int i = 0; i < 300; i++) begin
      ref_c = model(ref_c, 8'(i * 37 + 5), 2'd1, 1'b0);
      send(8'(i * 37 + 5));
    end
    chk("R9 long stream 0x8005", crc_out, ref_c);

    set_cfg(2'd2, 1'b1);
    ref_c = '0;
    for (int i = 0; i < 257; i++) begin
      ref_c = model(ref_c, 8'(i ^ (i >> 3)), 2'd2, 1'b1);
      send(8'(i ^ (i >> 3)));
    end
    chk("R9 long stream reflected 0x1021", crc_out, ref_c);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule